// File: doc/BRIEF.md
# Two-Road Intersection Signal Controller

This block drives the signal lamps of a single crossing where road A meets road B. Each road has a vehicle-presence sensor and a two-bit lamp output. The lamps follow the traffic seen on the sensors rather than a fixed timer: road A keeps its green while cars keep arriving on it, then the lamps step through a one-cycle amber phase to give road B its green. Road B keeps green while its own sensor is active, then steps back through amber.

The control is split into two cooperating state machines. A two-state mode machine tracks a parade condition: a parade request puts it in parade mode, and a release input brings it back to normal operation, with the release winning if both arrive together. The mode machine's registered output feeds the lamp machine, which then steers toward road B green and holds it there, regardless of sensors, until parade mode ends. Both machines share one clock and a synchronous, active-high reset. The lamp outputs depend only on the lamp state.

Top module: `xroad_signal_ctrl`

## Requirements
- R1: After synchronous reset the lamp machine is in the A-green phase (lamp_a = 00, lamp_b = 10) and the mode machine is normal, so a parade effect is absent on the cycle after reset is released.
- R2: In the A-green phase (state code 00) with parade mode inactive, the phase is held while sense_a is 1 and moves to A-amber (code 01) on the clock edge where sense_a is 0.
- R3: The A-amber phase (code 01) always moves to B-green (code 10) on the next edge, and the B-amber phase (code 11) always moves to A-green (code 00) on the next edge, whatever the inputs.
- R4: In the B-green phase (code 10) with parade mode inactive, the phase is held while sense_b is 1 and moves to B-amber (code 11) on the edge where sense_b is 0.
- R5: Lamp codes are green = 00, amber = 01, red = 10. Per phase (lamp_a, lamp_b): 00 gives (00,10), 01 gives (01,10), 10 gives (10,00), 11 gives (10,01). The code 11 never appears on either lamp output.
- R6: At no cycle are both lamp outputs something other than red.
- R7: parade_req = 1 at an edge puts the mode machine into parade mode, which the lamp machine sees from the following edge on; parade_end = 1 at an edge returns it to normal, visible to the lamp machine from the following edge; when both are 1 in one cycle, parade_end wins.
- R8: While parade mode is active, the A-green phase advances at the next edge even with sense_a = 1, and the B-green phase holds even with sense_b = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sense_a | input | 1 | Vehicle present on road A |
| sense_b | input | 1 | Vehicle present on road B |
| parade_req | input | 1 | Request to enter parade mode |
| parade_end | input | 1 | Release from parade mode |
| lamp_a | output | 2 | Road A lamp: 00 green, 01 amber, 10 red |
| lamp_b | output | 2 | Road B lamp: 00 green, 01 amber, 10 red |

## Verification
The lamp sequence is first walked with sensor patterns alone, holding each green for several cycles and then dropping the sensor, which separates the sensor-held phases from the unconditional amber phases. Parade requests are then issued while road A is green with its sensor active, showing that the mode register adds exactly one cycle before the lamp machine reacts, and a B-green hold with sense_b low shows the parade override of the sensor. A request and release in the same cycle, a release issued during amber, and a reset in the middle of a parade distinguish the release priority and the reset state from the normal flow.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

  localparam int LAMP_W  = 2;
  localparam int PHASE_W = 2;

  localparam logic [LAMP_W-1:0] LAMP_GREEN = 2'b00;
  localparam logic [LAMP_W-1:0] LAMP_AMBER = 2'b01;
  localparam logic [LAMP_W-1:0] LAMP_RED   = 2'b10;

  typedef enum logic [PHASE_W-1:0] {
    PH_A_GO   = 2'b00,
    PH_A_WARN = 2'b01,
    PH_B_GO   = 2'b10,
    PH_B_WARN = 2'b11
  } phase_t;

  typedef enum logic {
    MD_NORMAL = 1'b0,
    MD_PARADE = 1'b1
  } mode_t;

  function automatic mode_t mode_next(mode_t cur, logic req, logic rel);
    if (rel)      return MD_NORMAL;
    else if (req) return MD_PARADE;
    else          return cur;
  endfunction

  function automatic phase_t phase_next(phase_t cur, logic sa, logic sb, logic parade);
    case (cur)
      PH_A_GO:   return (!sa || parade) ? PH_A_WARN : PH_A_GO;
      PH_A_WARN: return PH_B_GO;
      PH_B_GO:   return (sb || parade) ? PH_B_GO : PH_B_WARN;
      default:   return PH_A_GO;
    endcase
  endfunction

  // Road A: red in the B half of the cycle, amber only in A-warn.
  function automatic logic [LAMP_W-1:0] lamp_for_a(phase_t ph);
    logic [PHASE_W-1:0] s;
    s = ph;
    return {s[1], ~s[1] & s[0]};
  endfunction

  // Road B: red in the A half of the cycle, amber only in B-warn.
  function automatic logic [LAMP_W-1:0] lamp_for_b(phase_t ph);
    logic [PHASE_W-1:0] s;
    s = ph;
    return {~s[1], s[1] & s[0]};
  endfunction

endpackage

// File: rtl/xrs_mode_fsm.sv
module xrs_mode_fsm
  import xrs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic rel,
  output logic parade_on
);

  mode_t mode_q;
  mode_t mode_d;

  always_comb mode_d = mode_next(mode_q, req, rel);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MD_NORMAL;
    else     mode_q <= mode_d;
  end

  assign parade_on = (mode_q == MD_PARADE);

  AST_RELEASE_WINS: assert property (@(posedge clk) disable iff (rst)
    rel |=> !parade_on); // R7
  AST_REQUEST_ENTERS: assert property (@(posedge clk) disable iff (rst)
    (req && !rel) |=> parade_on); // R7
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!req && !rel) |=> (parade_on == $past(parade_on))); // R7

endmodule

// File: rtl/xrs_light_fsm.sv
module xrs_light_fsm
  import xrs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sense_a,
  input  logic   sense_b,
  input  logic   parade_on,
  output phase_t phase
);

  phase_t phase_q;
  phase_t phase_d;

  // Named events for the checks below.
  logic in_a_go, in_b_go, a_go_hold, b_go_hold;
  assign in_a_go   = (phase_q == PH_A_GO);
  assign in_b_go   = (phase_q == PH_B_GO);
  assign a_go_hold = in_a_go && sense_a && !parade_on;
  assign b_go_hold = in_b_go && (sense_b || parade_on);

  always_comb phase_d = phase_next(phase_q, sense_a, sense_b, parade_on);

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_A_GO;
    else     phase_q <= phase_d;
  end

  assign phase = phase_q;

  AST_A_GO_HOLD: assert property (@(posedge clk) disable iff (rst)
    a_go_hold |=> (phase_q == PH_A_GO)); // R2
  AST_A_GO_LEAVE: assert property (@(posedge clk) disable iff (rst)
    (in_a_go && !a_go_hold) |=> (phase_q == PH_A_WARN)); // R8
  AST_A_WARN_STEP: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_A_WARN) |=> (phase_q == PH_B_GO)); // R3
  AST_B_GO_HOLD: assert property (@(posedge clk) disable iff (rst)
    b_go_hold |=> (phase_q == PH_B_GO)); // R4
  AST_B_GO_LEAVE: assert property (@(posedge clk) disable iff (rst)
    (in_b_go && !b_go_hold) |=> (phase_q == PH_B_WARN)); // R4
  AST_B_WARN_STEP: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_B_WARN) |=> (phase_q == PH_A_GO)); // R3

endmodule

// File: rtl/xrs_lamp_decode.sv
module xrs_lamp_decode
  import xrs_pkg::*;
(
  input  phase_t              phase,
  output logic [LAMP_W-1:0]   lamp_a,
  output logic [LAMP_W-1:0]   lamp_b
);

  assign lamp_a = lamp_for_a(phase);
  assign lamp_b = lamp_for_b(phase);

  always_comb begin
    AST_NO_CODE_11: assert (lamp_a != 2'b11 && lamp_b != 2'b11); // R5
  end

endmodule

// File: rtl/xroad_signal_ctrl.sv
module xroad_signal_ctrl
  import xrs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sense_a,
  input  logic              sense_b,
  input  logic              parade_req,
  input  logic              parade_end,
  output logic [1:0]        lamp_a,
  output logic [1:0]        lamp_b
);

  logic   parade_on;
  phase_t phase;

  xrs_mode_fsm u_mode (
    .clk       (clk),
    .rst       (rst),
    .req       (parade_req),
    .rel       (parade_end),
    .parade_on (parade_on)
  );

  xrs_light_fsm u_light (
    .clk       (clk),
    .rst       (rst),
    .sense_a   (sense_a),
    .sense_b   (sense_b),
    .parade_on (parade_on),
    .phase     (phase)
  );

  xrs_lamp_decode u_decode (
    .phase  (phase),
    .lamp_a (lamp_a),
    .lamp_b (lamp_b)
  );

  logic both_open;
  assign both_open = (lamp_a != LAMP_RED) && (lamp_b != LAMP_RED);

  AST_ONE_ROAD_OPEN: assert property (@(posedge clk) disable iff (rst)
    !both_open); // R6
  AST_RESET_A_GREEN: assert property (@(posedge clk)
    rst |=> (lamp_a == LAMP_GREEN && lamp_b == LAMP_RED)); // R1

endmodule

// File: tb/test_xroad_signal_ctrl.sv
module test_xroad_signal_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sense_a = 1'b0, sense_b = 1'b0, parade_req = 1'b0, parade_end = 1'b0;
  logic [1:0] lamp_a, lamp_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  xroad_signal_ctrl i_xroad_signal_ctrl (
    .clk(clk), .rst(rst), .sense_a(sense_a), .sense_b(sense_b),
    .parade_req(parade_req), .parade_end(parade_end),
    .lamp_a(lamp_a), .lamp_b(lamp_b)
  );

  localparam logic [1:0] G = 2'b00, Y = 2'b01, D = 2'b10;

  // {sense_a, sense_b, parade_req, parade_end, expected lamp_a, expected lamp_b}
  localparam int NV = 21;
  localparam logic [7:0] VEC [NV] = '{
    {4'b1000, G, D},  // R2 hold A-green while sense_a
    {4'b0000, Y, D},  // R2 leave on sense_a low
    {4'b0100, D, G},  // R3 amber to B-green
    {4'b0100, D, G},  // R4 hold while sense_b
    {4'b0000, D, Y},  // R4 leave on sense_b low
    {4'b0000, G, D},  // R3 B-amber to A-green
    {4'b1010, G, D},  // R7 request, not yet seen
    {4'b1000, Y, D},  // R8 A-green leaves with sense_a high
    {4'b1000, D, G},  // R3
    {4'b0000, D, G},  // R8 B-green holds with sense_b low
    {4'b1000, D, G},  // R8
    {4'b0001, D, G},  // R7 release, not yet seen
    {4'b0000, D, Y},  // R7 normal again
    {4'b0000, G, D},  // R3
    {4'b1011, G, D},  // R7 request and release together
    {4'b1000, G, D},  // R7 release won: A-green holds
    {4'b1010, G, D},  // R7 request
    {4'b1000, Y, D},  // R8
    {4'b0001, D, G},  // R7 release during amber
    {4'b0000, D, Y},  // R4 sensor governs again
    {4'b0000, G, D}   // R3
  };

  task automatic check(string req, logic [1:0] ea, logic [1:0] eb);
    n_chk++;
    if (lamp_a !== ea || lamp_b !== eb) begin
      n_bad++;
      $display("FAIL %s: lamp_a/lamp_b = %b/%b, expected %b/%b", req, lamp_a, lamp_b, ea, eb);
    end
    if (lamp_a === 2'b11 || lamp_b === 2'b11) begin
      n_bad++;
      $display("FAIL R5: unused code, lamp_a/lamp_b = %b/%b, expected no 11", lamp_a, lamp_b);
    end
    if (lamp_a !== D && lamp_b !== D) begin
      n_bad++;
      $display("FAIL R6: lamp_a/lamp_b = %b/%b, expected one red", lamp_a, lamp_b);
    end
  endtask

  task automatic step(logic [3:0] in);
    {sense_a, sense_b, parade_req, parade_end} = in;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    step(4'b1000);
    rst = 1'b0;
    check("R1 reset state", G, D);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][7:4]);
      check($sformatf("vector %0d", i), VEC[i][3:2], VEC[i][1:0]);
    end

    // R1: reset in the middle of a parade hold
    step(4'b0010);           // A-green, parade requested
    step(4'b1000);           // A-amber
    step(4'b0000);           // B-green, held by parade
    check("R8 parade B-green", D, G);
    rst = 1'b1;
    step(4'b0000);
    check("R1 reset from B-green", G, D);
    rst = 1'b0;
    step(4'b1000);           // parade cleared: A-green must hold
    check("R1 mode cleared by reset", G, D);
    step(4'b1000);
    check("R1 mode cleared by reset", G, D);

    // R3: amber phases ignore sensors and parade inputs
    step(4'b0000);
    check("R2 leave A-green", Y, D);
    step(4'b1111);
    check("R3 A-amber ignores inputs", D, G);
    step(4'b0001);
    check("R4 leave B-green", D, Y);
    step(4'b0110);
    check("R3 B-amber ignores inputs", G, D);
    done = 1;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: done = 0, expected 1");
    end
  end

  initial begin
    wait (done);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2001) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule